// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block runs in-band (software) flow control for one serial channel. On the receive side it looks at every incoming character. When a programmed stop character arrives, it pauses the local transmitter. When the matching go character arrives, the transmitter runs again. A matched flow character is consumed: the block raises a drop strobe in the same cycle, so the character is not written to the receive FIFO. Each match also sets a sticky flag, and reading the flags clears them.

On the other side, the block watches the receive FIFO fill level against two 4-bit thresholds, each counted in units of eight words. When the level reaches the halt threshold, the block asks the serializer to send a stop character to the far end. When the level falls back to the resume threshold, it asks for a go character. The serializer takes a pending request at its next character boundary, ahead of FIFO data, and acknowledges it with a one-cycle strobe.

There are two character sets, A and B. A 2-bit selector on each side picks set A, set B, or both. On the receive side, "both" means a two-character sequence. On the sending side, "both" means the pair is sent in sequence. The FIFOs and the serializer are outside the block.

Top module: `xfc_top`

## Requirements
- R1: With the receive-side selector `flowMode[1:0]` = 2'b10, a received `xoffA` sets `txHalt` on the next cycle and a received `xonA` clears it; set-B characters and other data leave `txHalt` unchanged.
- R2: With `flowMode[1:0]` = 2'b01, only `xoffB` and `xonB` halt and release the transmitter; set-A characters have no effect.
- R3: With `flowMode[1:0]` = 2'b11, the transmitter halts only after `xoffA` is immediately followed by `xoffB`, and releases only after `xonA` is immediately followed by `xonB`. Any other word in between discards the partial match.
- R4: With `flowMode[1:0]` = 2'b00, `txHalt` is 0, no character is dropped and no flag is set.
- R5: `rxDrop` is high during the same cycle as `rxValid` for a character that completes a match (a single-mode match, or the second character of a sequence). The lead character of a sequence and non-matching data are not dropped.
- R6: `matchFlags` bit 0 is set by `xonA`, bit 1 by `xonB`, bit 2 by `xoffA` and bit 3 by `xoffB`; a completed sequence sets both bits of its pair. Flags become visible one cycle after the character. A one-cycle `flagRead` clears them, but a flag set in the same cycle survives the read.
- R7: With the send-side selector `flowMode[3:2]` nonzero and `haltLvl` nonzero, the block asserts `insReq` with a stop character one cycle after `rxLevel` first reaches `haltLvl`*8. It makes only one such request until a resume occurs. A `haltLvl` of 0 disables generation.
- R8: After a halt request, the block asserts `insReq` with a go character one cycle after `rxLevel` falls to `resumeLvl`*8 or below.
- R9: The character sent depends on `flowMode[3:2]`: 2'b10 sends the set-A character, 2'b01 sends the set-B character, and 2'b11 sends A then B. Each character is retired by one `insAck`, and the request drops after the last one.
- R10: A new halt or resume request replaces a pending, unacknowledged one, and restarts from the first character of the new pair.
- R11: With `flowMode[3:2]` = 2'b00, `insReq` is 0 from the next cycle and the throttle state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | Received-character strobe |
| rxData | input | 8 | Received character |
| rxLevel | input | 8 | Receive FIFO fill level in words |
| xonA | input | 8 | Go character, set A |
| xonB | input | 8 | Go character, set B |
| xoffA | input | 8 | Stop character, set A |
| xoffB | input | 8 | Stop character, set B |
| flowMode | input | 4 | [3:2] send-side selector, [1:0] receive-side selector |
| haltLvl | input | 4 | Halt threshold in units of 8 words |
| resumeLvl | input | 4 | Resume threshold in units of 8 words |
| insAck | input | 1 | Serializer took the offered flow character |
| flagRead | input | 1 | Flag read strobe (clears flags) |
| txHalt | output | 1 | Pause the local transmitter |
| rxDrop | output | 1 | Current received character is consumed, not stored |
| insReq | output | 1 | Flow character insertion requested |
| insChar | output | 8 | Character to insert |
| matchFlags | output | 4 | Sticky match flags |

## Verification
Some properties are checked on every cycle. The transmitter halt can rise only just after a received character. A disabled selector forces the halt and the insertion request low. A flag read with nothing new to set leaves the flags clear. Other behaviour only the directed scenarios can show, because it depends on particular character values and level sequences. This covers which character set each selector value honours, breaking a two-character sequence, the set-versus-read race on the flags, the threshold edges, the two-character send order, and replacement of a pending request.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int NUM_CHARS = 4;
  localparam int IDX_XON_A = 0;
  localparam int IDX_XON_B = 1;
  localparam int IDX_XOFF_A = 2;
  localparam int IDX_XOFF_B = 3;

  typedef struct packed {
    logic xoffB;
    logic xoffA;
    logic xonB;
    logic xonA;
  } hitT;

  typedef struct packed {
    logic [NUM_CHARS-1:0] flagSet;
    logic                 rxDrop;
    logic [1:0]           insSel;
  } strobeT;
endpackage

// File: rtl/xfc_datapath.sv
module xfc_datapath
  import xfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHAR_W-1:0]    rxData,
  input  logic [CHAR_W-1:0]    xonA,
  input  logic [CHAR_W-1:0]    xonB,
  input  logic [CHAR_W-1:0]    xoffA,
  input  logic [CHAR_W-1:0]    xoffB,
  input  logic                 flagRead,
  input  strobeT               strobes,
  output hitT                  hits,
  output logic [CHAR_W-1:0]    insChar,
  output logic [NUM_CHARS-1:0] matchFlags
);
  logic [CHAR_W-1:0] charTab [NUM_CHARS];
  logic [NUM_CHARS-1:0] hitVec;
  logic [NUM_CHARS-1:0] flagsQ;

  assign charTab[IDX_XON_A]  = xonA;
  assign charTab[IDX_XON_B]  = xonB;
  assign charTab[IDX_XOFF_A] = xoffA;
  assign charTab[IDX_XOFF_B] = xoffB;

  for (genvar i = 0; i < NUM_CHARS; i++) begin : gCmp
    assign hitVec[i] = (rxData == charTab[i]);
  end

  assign hits.xonA  = hitVec[IDX_XON_A];
  assign hits.xonB  = hitVec[IDX_XON_B];
  assign hits.xoffA = hitVec[IDX_XOFF_A];
  assign hits.xoffB = hitVec[IDX_XOFF_B];

  assign insChar = charTab[strobes.insSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagRead ? '0 : flagsQ) | strobes.flagSet;
  end

  assign matchFlags = flagsQ;

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && strobes.flagSet == '0) |=> (matchFlags == '0)); // R6
endmodule

// File: rtl/xfc_ctrl.sv
module xfc_ctrl
  import xfc_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int THR_W    = 4,
  parameter int THR_UNIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  hitT              hits,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [3:0]       flowMode,
  input  logic [THR_W-1:0] haltLvl,
  input  logic [THR_W-1:0] resumeLvl,
  input  logic             insAck,
  output strobeT           strobes,
  output logic             txHalt,
  output logic             insReq
);
  localparam int UNIT_SH = $clog2(THR_UNIT);

  logic [1:0] txMode, rxMode;
  assign txMode = flowMode[1:0];
  assign rxMode = flowMode[3:2];

  logic txHaltQ, txHaltD;
  logic leadOnQ, leadOnD, leadOffQ, leadOffD;
  logic [NUM_CHARS-1:0] flagSet;
  logic dropNow;

  // receive-side character matching
  always_comb begin
    txHaltD  = txHaltQ;
    leadOnD  = leadOnQ;
    leadOffD = leadOffQ;
    flagSet  = '0;
    dropNow  = 1'b0;
    if (txMode == 2'b00) begin
      txHaltD  = 1'b0;
      leadOnD  = 1'b0;
      leadOffD = 1'b0;
    end else if (rxValid) begin
      leadOnD  = 1'b0;
      leadOffD = 1'b0;
      case (txMode)
        2'b10: begin
          if (hits.xoffA) begin
            txHaltD = 1'b1; dropNow = 1'b1; flagSet[IDX_XOFF_A] = 1'b1;
          end else if (hits.xonA) begin
            txHaltD = 1'b0; dropNow = 1'b1; flagSet[IDX_XON_A] = 1'b1;
          end
        end
        2'b01: begin
          if (hits.xoffB) begin
            txHaltD = 1'b1; dropNow = 1'b1; flagSet[IDX_XOFF_B] = 1'b1;
          end else if (hits.xonB) begin
            txHaltD = 1'b0; dropNow = 1'b1; flagSet[IDX_XON_B] = 1'b1;
          end
        end
        default: begin
          if (leadOffQ && hits.xoffB) begin
            txHaltD = 1'b1; dropNow = 1'b1;
            flagSet[IDX_XOFF_A] = 1'b1; flagSet[IDX_XOFF_B] = 1'b1;
          end else if (leadOnQ && hits.xonB) begin
            txHaltD = 1'b0; dropNow = 1'b1;
            flagSet[IDX_XON_A] = 1'b1; flagSet[IDX_XON_B] = 1'b1;
          end else begin
            leadOffD = hits.xoffA;
            leadOnD  = hits.xonA;
          end
        end
      endcase
    end
  end

  // send-side threshold watch and insertion queue
  logic [LVL_W-1:0] haltWords, resumeWords;
  assign haltWords   = LVL_W'(haltLvl) << UNIT_SH;
  assign resumeWords = LVL_W'(resumeLvl) << UNIT_SH;

  logic thrQ, thrD, pendQ, pendD, pendOffQ, pendOffD, pendSecQ, pendSecD;

  always_comb begin
    thrD     = thrQ;
    pendD    = pendQ;
    pendOffD = pendOffQ;
    pendSecD = pendSecQ;
    if (rxMode == 2'b00 || haltLvl == '0) begin
      thrD     = 1'b0;
      pendD    = 1'b0;
      pendSecD = 1'b0;
    end else begin
      if (insAck && pendQ) begin
        if (rxMode == 2'b11 && !pendSecQ) pendSecD = 1'b1;
        else begin
          pendD    = 1'b0;
          pendSecD = 1'b0;
        end
      end
      if (!thrQ && rxLevel >= haltWords) begin
        thrD = 1'b1; pendD = 1'b1; pendOffD = 1'b1; pendSecD = 1'b0;
      end else if (thrQ && rxLevel <= resumeWords) begin
        thrD = 1'b0; pendD = 1'b1; pendOffD = 1'b0; pendSecD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHaltQ  <= 1'b0;
      leadOnQ  <= 1'b0;
      leadOffQ <= 1'b0;
      thrQ     <= 1'b0;
      pendQ    <= 1'b0;
      pendOffQ <= 1'b0;
      pendSecQ <= 1'b0;
    end else begin
      txHaltQ  <= txHaltD;
      leadOnQ  <= leadOnD;
      leadOffQ <= leadOffD;
      thrQ     <= thrD;
      pendQ    <= pendD;
      pendOffQ <= pendOffD;
      pendSecQ <= pendSecD;
    end
  end

  assign strobes.flagSet = flagSet;
  assign strobes.rxDrop  = dropNow;
  assign strobes.insSel  = {pendOffQ, (rxMode == 2'b01) | pendSecQ};
  assign txHalt = txHaltQ;
  assign insReq = pendQ;

  AST_HALT_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txHalt) |-> $past(rxValid)); // R1
  AST_TX_SIDE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == 2'b00) |=> !txHalt); // R4
  AST_RX_SIDE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode == 2'b00) |=> !insReq); // R11
endmodule

// File: rtl/xfc_top.sv
module xfc_top
  import xfc_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = 4,
  parameter int THR_UNIT   = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [CHAR_W-1:0] xonA,
  input  logic [CHAR_W-1:0] xonB,
  input  logic [CHAR_W-1:0] xoffA,
  input  logic [CHAR_W-1:0] xoffB,
  input  logic [3:0]        flowMode,
  input  logic [THR_W-1:0]  haltLvl,
  input  logic [THR_W-1:0]  resumeLvl,
  input  logic              insAck,
  input  logic              flagRead,
  output logic              txHalt,
  output logic              rxDrop,
  output logic              insReq,
  output logic [CHAR_W-1:0] insChar,
  output logic [3:0]        matchFlags
);
  hitT    hits;
  strobeT strobes;

  xfc_ctrl #(.LVL_W(LVL_W), .THR_W(THR_W), .THR_UNIT(THR_UNIT)) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .hits(hits),
    .rxLevel(rxLevel), .flowMode(flowMode), .haltLvl(haltLvl),
    .resumeLvl(resumeLvl), .insAck(insAck), .strobes(strobes),
    .txHalt(txHalt), .insReq(insReq)
  );

  xfc_datapath #(.CHAR_W(CHAR_W)) uData (
    .clk(clk), .rstN(rstN), .rxData(rxData), .xonA(xonA), .xonB(xonB),
    .xoffA(xoffA), .xoffB(xoffB), .flagRead(flagRead), .strobes(strobes),
    .hits(hits), .insChar(insChar), .matchFlags(matchFlags)
  );

  assign rxDrop = strobes.rxDrop;
endmodule

// File: tb/xfc_top_test.sv
module xfc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON_A = 8'h11, XON_B = 8'h13, XOFF_A = 8'h19, XOFF_B = 8'h17;

  logic clk = 0, rstN = 0, rxValid = 0, insAck = 0, flagRead = 0;
  logic [7:0] rxData = 0, rxLevel = 0;
  logic [3:0] flowMode = 0, haltLvl = 0, resumeLvl = 0;
  logic txHalt, rxDrop, insReq;
  logic [7:0] insChar;
  logic [3:0] matchFlags;
  int nChecks = 0, nFails = 0;
  logic lastDrop;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfc_top uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLevel(rxLevel),
    .xonA(XON_A), .xonB(XON_B), .xoffA(XOFF_A), .xoffB(XOFF_B),
    .flowMode(flowMode), .haltLvl(haltLvl), .resumeLvl(resumeLvl),
    .insAck(insAck), .flagRead(flagRead), .txHalt(txHalt), .rxDrop(rxDrop),
    .insReq(insReq), .insChar(insChar), .matchFlags(matchFlags)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one character for one cycle; rxDrop sampled mid-cycle
  task automatic sendChar(logic [7:0] d);
    @(negedge clk);
    rxValid = 1; rxData = d;
    #1 lastDrop = rxDrop;
    @(negedge clk);
    rxValid = 0; rxData = 8'h00;
  endtask

  task automatic readFlags();
    @(negedge clk); flagRead = 1;
    @(negedge clk); flagRead = 0;
  endtask

  task automatic ack();
    @(negedge clk); insAck = 1;
    @(negedge clk); insAck = 0;
  endtask

  task automatic setLevel(logic [7:0] l);
    @(negedge clk); rxLevel = l;
    @(negedge clk);
  endtask

  task automatic clean();
    @(negedge clk); flowMode = 0; rxLevel = 0; haltLvl = 0; resumeLvl = 0;
    @(negedge clk);
    readFlags();
  endtask

  task automatic t_reset();
    chk("reset txHalt", txHalt, 0);
    chk("reset insReq", insReq, 0);
    chk("reset flags", matchFlags, 0);
  endtask

  task automatic t_setA();
    clean(); flowMode = 4'b0010;
    sendChar(XOFF_B);
    chk("R1 set B ignored halt", txHalt, 0);
    chk("R1 set B not dropped", lastDrop, 0);
    sendChar(XOFF_A);
    chk("R1 xoffA halts", txHalt, 1);
    chk("R5 xoffA dropped", lastDrop, 1);
    chk("R6 flag bit2", matchFlags, 4'b0100);
    readFlags();
    chk("R6 read clears", matchFlags, 0);
    sendChar(8'h41);
    chk("R1 data keeps halt", txHalt, 1);
    chk("R5 data not dropped", lastDrop, 0);
    sendChar(XON_A);
    chk("R1 xonA releases", txHalt, 0);
    chk("R6 flag bit0", matchFlags, 4'b0001);
  endtask

  task automatic t_setB();
    clean(); flowMode = 4'b0001;
    sendChar(XOFF_A);
    chk("R2 set A ignored", txHalt, 0);
    sendChar(XOFF_B);
    chk("R2 xoffB halts", txHalt, 1);
    sendChar(XON_A);
    chk("R2 xonA ignored", txHalt, 1);
    sendChar(XON_B);
    chk("R2 xonB releases", txHalt, 0);
    chk("R6 flags bit3 bit1", matchFlags, 4'b1010);
  endtask

  task automatic t_seq();
    clean(); flowMode = 4'b0011;
    sendChar(XOFF_A);
    chk("R3 lead alone no halt", txHalt, 0);
    chk("R5 lead not dropped", lastDrop, 0);
    sendChar(XOFF_B);
    chk("R3 pair halts", txHalt, 1);
    chk("R5 second dropped", lastDrop, 1);
    chk("R6 pair flags", matchFlags, 4'b1100);
    sendChar(XON_A); sendChar(8'h55); sendChar(XON_B);
    chk("R3 broken pair ignored", txHalt, 1);
    chk("R5 broken second kept", lastDrop, 0);
    sendChar(XON_A); sendChar(XON_B);
    chk("R3 pair releases", txHalt, 0);
  endtask

  task automatic t_off();
    clean(); flowMode = 4'b0000;
    sendChar(XOFF_A);
    chk("R4 no halt", txHalt, 0);
    chk("R4 no drop", lastDrop, 0);
    chk("R4 no flags", matchFlags, 0);
  endtask

  task automatic t_flagRace();
    clean(); flowMode = 4'b0010;
    @(negedge clk); rxValid = 1; rxData = XON_A; flagRead = 1;
    @(negedge clk); rxValid = 0; flagRead = 0;
    chk("R6 set wins over read", matchFlags, 4'b0001);
  endtask

  task automatic t_thresh();
    clean(); flowMode = 4'b1000; haltLvl = 4; resumeLvl = 1;
    setLevel(31);
    chk("R7 below halt", insReq, 0);
    setLevel(32);
    chk("R7 halt request", insReq, 1);
    chk("R9 set A stop char", insChar, XOFF_A);
    ack();
    chk("R9 retired", insReq, 0);
    setLevel(40);
    chk("R7 single request", insReq, 0);
    setLevel(9);
    chk("R8 above resume", insReq, 0);
    setLevel(8);
    chk("R8 resume request", insReq, 1);
    chk("R8 go char", insChar, XON_A);
    ack();
    chk("R8 retired", insReq, 0);
  endtask

  task automatic t_pair();
    clean(); flowMode = 4'b1100; haltLvl = 2; resumeLvl = 0;
    setLevel(16);
    chk("R9 pair first", insChar, XOFF_A);
    ack();
    chk("R9 pair pending", insReq, 1);
    chk("R9 pair second", insChar, XOFF_B);
    ack();
    chk("R9 pair done", insReq, 0);
  endtask

  task automatic t_setBsend();
    clean(); flowMode = 4'b0100; haltLvl = 1;
    setLevel(8);
    chk("R9 set B stop char", insChar, XOFF_B);
  endtask

  task automatic t_replace();
    clean(); flowMode = 4'b1100; haltLvl = 3; resumeLvl = 1;
    setLevel(30);
    ack();
    chk("R10 on second", insChar, XOFF_B);
    setLevel(0);
    chk("R10 replaced req", insReq, 1);
    chk("R10 restarts at first", insChar, XON_A);
  endtask

  task automatic t_disable();
    clean(); flowMode = 4'b1000; haltLvl = 1;
    setLevel(20);
    chk("R11 precondition", insReq, 1);
    @(negedge clk); flowMode = 4'b0000;
    @(negedge clk);
    chk("R11 off clears request", insReq, 0);
    @(negedge clk); flowMode = 4'b1000; haltLvl = 0; rxLevel = 120;
    @(negedge clk); @(negedge clk);
    chk("R7 zero threshold disabled", insReq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        t_reset();
        t_setA(); t_setB(); t_seq(); t_off(); t_flagRace();
        t_thresh(); t_pair(); t_setBsend(); t_replace(); t_disable();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule